// File: doc/BRIEF.md
# Flag Offset Register Bank

This block holds the two thresholds used by a clocked FIFO's almost-empty and almost-full flags. Each threshold is split into a low register as wide as the data bus and a high register that carries the remaining upper bits for the configured depth. The block serves two clock domains. Host writes arrive on the write clock. Readback and the almost-empty threshold are on the read clock. The almost-full threshold stays in the write domain.

The role of the dual-purpose load pin is fixed during reset. If the pin is low while reset is asserted, the block enters offset-load mode. In that mode, driving the pin low turns the data bus into a register port. No register address is supplied. A write-side selector and a separate read-side selector each step through the four registers in a fixed cycle, one register per access, and wrap around. Each selector keeps its position when the pin goes high and low again between sessions. If the pin is high while reset is asserted, it acts as a second write enable, and register access is closed until the next reset.

After every register write, a request/acknowledge handshake copies a snapshot of the whole bank into a shadow copy in the read domain. Readback and the almost-empty threshold both come from this shadow copy. The block also produces the qualified FIFO write and read requests, so that a register access replaces a data access.

Top module: `flag_ofs_bank`

## Requirements
- R1: The load mode is latched from `ld_n` while `rst` is high: low selects offset-load mode, high selects two-enable mode. In two-enable mode, register writes and readbacks never happen: `full_ofs_w`, `empty_ofs_r` and `cfg_dout` keep their values.
- R2: After reset, both low registers hold 7 and both high registers hold 0. `full_ofs_w` and `empty_ofs_r` equal 7, `cfg_dout` is 0, and both selectors point at the empty-low register.
- R3: In offset-load mode, each `wclk` rising edge with `ld_n` low and `wen_n` low writes `din` into the register under the write selector. The selector then advances in the order empty-low (0), empty-high (1), full-low (2), full-high (3), and returns to empty-low after full-high.
- R4: A low register stores all `DATA_W` bits of `din`. A high register keeps only the low `HI_W` bits and reads back zero-extended. `full_ofs_w` equals {full-high, full-low}, and it takes a new value on the same `wclk` edge that writes either of those registers.
- R5: Raising `ld_n` ends a session without moving either selector. The next write or read resumes at the following register.
- R6: In offset-load mode, each `rclk` rising edge with `ld_n` low and both `ren_a_n` and `ren_b_n` low loads the register under the read selector onto `cfg_dout`. The read selector advances in the R3 order with the same wrap. `cfg_dout` holds its value on every other edge.
- R7: Within 12 `rclk` cycles after a register write, `empty_ofs_r` equals {empty-high, empty-low}, and readback returns the written values.
- R8: `fifo_wr_req` is high exactly when `wen_n` is low and `ld_n` is high. `fifo_rd_req` is high exactly when both read enables are low, unless offset-load mode is latched and `ld_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| ld_n | input | 1 | Load pin, active low; sampled in reset to choose the mode |
| wen_n | input | 1 | Write enable, active low |
| din | input | DATA_W | Write data bus |
| ren_a_n | input | 1 | First read enable, active low |
| ren_b_n | input | 1 | Second read enable, active low |
| cfg_dout | output | DATA_W | Offset register readback value |
| full_ofs_w | output | OFS_W | Almost-full threshold, write domain |
| empty_ofs_r | output | OFS_W | Almost-empty threshold, read domain |
| fifo_wr_req | output | 1 | Qualified FIFO data write request |
| fifo_rd_req | output | 1 | Qualified FIFO data read request |

## Verification
The assertions assume three things about the inputs:
- `rst` stays high across several edges of both clocks, with `ld_n` steady, so that both domains latch the same mode.
- `ld_n` and the enables meet setup to whichever clock samples them.
- Offset writes and offset readbacks never overlap.

The bench respects all three. It changes the write-side inputs on falling `wclk` edges and the read enables on falling `rclk` edges. It holds `ld_n` steady through every reset. Each readback starts only after the last write session has ended and the shadow copy has had time to settle.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;

    // Register positions; the selectors walk them in this order and wrap.
    typedef enum logic [1:0] {
        SEL_EMPTY_LO = 2'd0,
        SEL_EMPTY_HI = 2'd1,
        SEL_FULL_LO  = 2'd2,
        SEL_FULL_HI  = 2'd3
    } ofs_sel_e;

    localparam int unsigned OFS_REGS   = 4;
    localparam int unsigned DEFAULT_LO = 7;

    function automatic ofs_sel_e sel_advance(input ofs_sel_e cur);
        logic [1:0] raw;
        raw = cur;
        raw = raw + 2'd1;
        return ofs_sel_e'(raw);
    endfunction

    // Low registers default to DEFAULT_LO, high registers to zero.
    function automatic int unsigned reset_value(input int unsigned idx);
        return (idx % 2 == 0) ? DEFAULT_LO : 0;
    endfunction

endpackage

// File: rtl/flag_ofs_sync.sv
module flag_ofs_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/flag_ofs_wr_bank.sv
module flag_ofs_wr_bank
    import flag_ofs_pkg::*;
#(
    parameter int unsigned DATA_W = 9,
    parameter int unsigned HI_W   = 5
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               ld_n,
    input  logic                               wen_n,
    input  logic [DATA_W-1:0]                  din,
    input  logic                               ack_sync,
    output logic                               load_mode,
    output ofs_sel_e                           wr_sel,
    output logic                               fifo_wr_req,
    output logic [OFS_REGS-1:0][DATA_W-1:0]    bank,
    output logic [OFS_REGS-1:0][DATA_W-1:0]    snap,
    output logic                               req
);
    localparam logic [DATA_W-1:0] HI_MASK = DATA_W'((1 << HI_W) - 1);

    logic wr_access;
    logic pending;
    logic launch;

    assign wr_access   = load_mode & ~ld_n & ~wen_n;
    assign fifo_wr_req = ~wen_n & ld_n;
    // A new snapshot leaves only once the previous one has been acknowledged.
    assign launch      = pending & (req == ack_sync);

    for (genvar g = 0; g < OFS_REGS; g++) begin : g_reg
        localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(reset_value(g));
        localparam logic [DATA_W-1:0] KEEP    = (g % 2 == 1) ? HI_MASK : {DATA_W{1'b1}};
        localparam ofs_sel_e          MY_SEL  = ofs_sel_e'(2'(g));

        logic [DATA_W-1:0] value_q;
        logic [DATA_W-1:0] snap_q;

        always_ff @(posedge clk) begin
            if (rst)                                value_q <= RST_VAL;
            else if (wr_access && wr_sel == MY_SEL) value_q <= din & KEEP;
        end

        always_ff @(posedge clk) begin
            if (rst)         snap_q <= RST_VAL;
            else if (launch) snap_q <= value_q;
        end

        assign bank[g] = value_q;
        assign snap[g] = snap_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_mode <= ~ld_n;
            wr_sel    <= SEL_EMPTY_LO;
            pending   <= 1'b0;
            req       <= 1'b0;
        end else begin
            pending <= wr_access | (pending & ~launch);
            if (launch)    req    <= ~req;
            if (wr_access) wr_sel <= sel_advance(wr_sel);
        end
    end
endmodule

// File: rtl/flag_ofs_rd_side.sv
module flag_ofs_rd_side
    import flag_ofs_pkg::*;
#(
    parameter int unsigned DATA_W = 9,
    parameter int unsigned HI_W   = 5
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               ld_n,
    input  logic                               ren_a_n,
    input  logic                               ren_b_n,
    input  logic                               req_sync,
    input  logic [OFS_REGS-1:0][DATA_W-1:0]    snap,
    output logic                               ack,
    output logic                               load_mode,
    output ofs_sel_e                           rd_sel,
    output logic [DATA_W-1:0]                  cfg_dout,
    output logic [DATA_W+HI_W-1:0]             empty_ofs,
    output logic                               fifo_rd_req
);
    logic                            cfg_access;
    logic                            capture;
    logic [OFS_REGS-1:0][DATA_W-1:0] shadow;

    assign cfg_access  = load_mode & ~ld_n & ~ren_a_n & ~ren_b_n;
    assign fifo_rd_req = ~ren_a_n & ~ren_b_n & ~(load_mode & ~ld_n);
    // The snapshot is steady while the request differs from the acknowledge.
    assign capture     = (req_sync != ack);

    for (genvar g = 0; g < OFS_REGS; g++) begin : g_shadow
        localparam logic [DATA_W-1:0] RST_VAL = DATA_W'(reset_value(g));
        logic [DATA_W-1:0] shadow_q;

        always_ff @(posedge clk) begin
            if (rst)          shadow_q <= RST_VAL;
            else if (capture) shadow_q <= snap[g];
        end

        assign shadow[g] = shadow_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_mode <= ~ld_n;
            ack       <= 1'b0;
            rd_sel    <= SEL_EMPTY_LO;
            cfg_dout  <= '0;
        end else begin
            if (capture) ack <= req_sync;
            if (cfg_access) begin
                cfg_dout <= shadow[rd_sel];
                rd_sel   <= sel_advance(rd_sel);
            end
        end
    end

    assign empty_ofs = {shadow[SEL_EMPTY_HI][HI_W-1:0], shadow[SEL_EMPTY_LO]};
endmodule

// File: rtl/flag_ofs_bank.sv
module flag_ofs_bank
    import flag_ofs_pkg::*;
#(
    parameter int unsigned DATA_W      = 9,
    parameter int unsigned DEPTH       = 16384,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned OFS_W      = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              ld_n,
    input  logic              wen_n,
    input  logic [DATA_W-1:0] din,
    input  logic              ren_a_n,
    input  logic              ren_b_n,
    output logic [DATA_W-1:0] cfg_dout,
    output logic [OFS_W-1:0]  full_ofs_w,
    output logic [OFS_W-1:0]  empty_ofs_r,
    output logic              fifo_wr_req,
    output logic              fifo_rd_req
);
    localparam int unsigned HI_W = OFS_W - DATA_W;

    logic                            req;
    logic                            ack;
    logic                            req_sync;
    logic                            ack_sync;
    logic                            load_mode_w;
    logic                            load_mode_r;
    ofs_sel_e                        wr_sel;
    ofs_sel_e                        rd_sel;
    logic [OFS_REGS-1:0][DATA_W-1:0] bank;
    logic [OFS_REGS-1:0][DATA_W-1:0] snap;

    flag_ofs_wr_bank #(.DATA_W(DATA_W), .HI_W(HI_W)) u_wr (
        .clk         (wclk),
        .rst         (rst),
        .ld_n        (ld_n),
        .wen_n       (wen_n),
        .din         (din),
        .ack_sync    (ack_sync),
        .load_mode   (load_mode_w),
        .wr_sel      (wr_sel),
        .fifo_wr_req (fifo_wr_req),
        .bank        (bank),
        .snap        (snap),
        .req         (req)
    );

    flag_ofs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (rclk), .rst (rst), .d (req), .q (req_sync)
    );

    flag_ofs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (wclk), .rst (rst), .d (ack), .q (ack_sync)
    );

    flag_ofs_rd_side #(.DATA_W(DATA_W), .HI_W(HI_W)) u_rd (
        .clk         (rclk),
        .rst         (rst),
        .ld_n        (ld_n),
        .ren_a_n     (ren_a_n),
        .ren_b_n     (ren_b_n),
        .req_sync    (req_sync),
        .snap        (snap),
        .ack         (ack),
        .load_mode   (load_mode_r),
        .rd_sel      (rd_sel),
        .cfg_dout    (cfg_dout),
        .empty_ofs   (empty_ofs_r),
        .fifo_rd_req (fifo_rd_req)
    );

    assign full_ofs_w = {bank[SEL_FULL_HI][HI_W-1:0], bank[SEL_FULL_LO]};
endmodule

// File: rtl/flag_ofs_bank_chk.sv
module flag_ofs_bank_chk #(
    parameter int unsigned DATA_W = 9,
    parameter int unsigned HI_W   = 5,
    parameter int unsigned OFS_W  = 14
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rst,
    input logic              ld_n,
    input logic              wen_n,
    input logic              ren_a_n,
    input logic              ren_b_n,
    input logic              load_mode_w,
    input logic              load_mode_r,
    input logic [1:0]        wr_sel,
    input logic [1:0]        rd_sel,
    input logic [OFS_W-1:0]  full_ofs_w,
    input logic [OFS_W-1:0]  empty_ofs_r,
    input logic [DATA_W-1:0] cfg_dout,
    input logic              fifo_wr_req
);
    logic wr_hit;
    logic rd_hit;
    assign wr_hit = load_mode_w & ~ld_n & ~wen_n;
    assign rd_hit = load_mode_r & ~ld_n & ~ren_a_n & ~ren_b_n;

    AST_MODE_FIXED: assert property (@(posedge wclk) disable iff (rst)
        !rst |=> $stable(load_mode_w)); // R1
    AST_PLAIN_EMPTY_HOLD: assert property (@(posedge rclk) disable iff (rst)
        !load_mode_r |=> $stable(empty_ofs_r)); // R1
    AST_WR_SEL_STEP: assert property (@(posedge wclk) disable iff (rst)
        wr_hit |=> (wr_sel == $past(wr_sel) + 2'd1)); // R3
    AST_WR_SEL_HOLD: assert property (@(posedge wclk) disable iff (rst)
        !wr_hit |=> $stable(wr_sel)); // R5
    AST_FULL_OFS_HOLD: assert property (@(posedge wclk) disable iff (rst)
        !wr_hit |=> $stable(full_ofs_w)); // R4
    AST_HI_ZERO_EXT: assert property (@(posedge rclk) disable iff (rst)
        (rd_hit && rd_sel[0]) |=> ((cfg_dout >> HI_W) == '0)); // R4
    AST_RD_SEL_STEP: assert property (@(posedge rclk) disable iff (rst)
        rd_hit |=> (rd_sel == $past(rd_sel) + 2'd1)); // R6
    AST_DOUT_HOLD: assert property (@(posedge rclk) disable iff (rst)
        !rd_hit |=> $stable(cfg_dout)); // R6
    AST_NO_FIFO_WR_IN_LOAD: assert property (@(posedge wclk) disable iff (rst)
        !ld_n |-> !fifo_wr_req); // R8
endmodule

bind flag_ofs_bank flag_ofs_bank_chk #(.DATA_W(DATA_W), .HI_W(HI_W), .OFS_W(OFS_W)) u_chk (
    .wclk        (wclk),
    .rclk        (rclk),
    .rst         (rst),
    .ld_n        (ld_n),
    .wen_n       (wen_n),
    .ren_a_n     (ren_a_n),
    .ren_b_n     (ren_b_n),
    .load_mode_w (load_mode_w),
    .load_mode_r (load_mode_r),
    .wr_sel      (wr_sel),
    .rd_sel      (rd_sel),
    .full_ofs_w  (full_ofs_w),
    .empty_ofs_r (empty_ofs_r),
    .cfg_dout    (cfg_dout),
    .fifo_wr_req (fifo_wr_req)
);

// File: tb/flag_ofs_bank_bench.sv
module flag_ofs_bank_bench;
    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_n = 1'b0;
    logic        wen_n = 1'b1;
    logic [8:0]  din = '0;
    logic        ren_a_n = 1'b1;
    logic        ren_b_n = 1'b1;
    logic [8:0]  cfg_dout;
    logic [13:0] full_ofs_w;
    logic [13:0] empty_ofs_r;
    logic        fifo_wr_req;
    logic        fifo_rd_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 wclk = ~wclk;
    initial begin
        #5;
        forever #10 rclk = ~rclk;
    end

    flag_ofs_bank u_flag_ofs_bank (
        .wclk (wclk), .rclk (rclk), .rst (rst), .ld_n (ld_n), .wen_n (wen_n),
        .din (din), .ren_a_n (ren_a_n), .ren_b_n (ren_b_n), .cfg_dout (cfg_dout),
        .full_ofs_w (full_ofs_w), .empty_ofs_r (empty_ofs_r),
        .fifo_wr_req (fifo_wr_req), .fifo_rd_req (fifo_rd_req)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input bit load);
        @(negedge wclk);
        rst = 1'b1; ld_n = ~load; wen_n = 1'b1; ren_a_n = 1'b1; ren_b_n = 1'b1; din = '0;
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        rst = 1'b0;
        repeat (3) @(negedge rclk);
    endtask

    task automatic wr_reg(input logic [8:0] val);
        @(negedge wclk);
        ld_n = 1'b0; wen_n = 1'b0; din = val;
        @(negedge wclk);
        wen_n = 1'b1;
    endtask

    task automatic rd_reg(input string req, input logic [8:0] exp);
        @(negedge rclk);
        ld_n = 1'b0; ren_a_n = 1'b0; ren_b_n = 1'b0;
        @(negedge rclk);
        ren_a_n = 1'b1; ren_b_n = 1'b1;
        check(req, "readback", 32'(cfg_dout), 32'(exp));
    endtask

    task automatic settle();
        repeat (12) @(negedge rclk);
    endtask

    task automatic t_reset_state();
        do_reset(1'b1);
        check("R2", "full offset after reset", 32'(full_ofs_w), 32'd7);
        check("R2", "empty offset after reset", 32'(empty_ofs_r), 32'd7);
        check("R2", "readback value after reset", 32'(cfg_dout), 32'd0);
        check("R8", "no fifo write", 32'(fifo_wr_req), 32'd0);
        check("R8", "no fifo read", 32'(fifo_rd_req), 32'd0);
    endtask

    task automatic t_default_readback();
        rd_reg("R2", 9'd7);
        rd_reg("R2", 9'd0);
        rd_reg("R6", 9'd7);
        rd_reg("R6", 9'd0);
    endtask

    task automatic t_full_sequence();
        wr_reg(9'h1AB);
        wr_reg(9'h1F5);
        check("R3", "full offset untouched by empty regs", 32'(full_ofs_w), 32'd7);
        wr_reg(9'h0F3);
        check("R4", "full offset after low write", 32'(full_ofs_w), 32'h0F3);
        wr_reg(9'h103);
        check("R4", "full offset after high write", 32'(full_ofs_w), 32'd1779);
        settle();
        check("R7", "empty offset after transfer", 32'(empty_ofs_r), 32'd11179);
        rd_reg("R7", 9'h1AB);
        rd_reg("R4", 9'h015);
        rd_reg("R6", 9'h0F3);
        rd_reg("R4", 9'h003);
        rd_reg("R6", 9'h1AB);   // fifth read wraps to empty-low
    endtask

    task automatic t_sessions();
        wr_reg(9'h055);          // fifth write wraps to empty-low (R3)
        @(negedge wclk);
        ld_n = 1'b1; wen_n = 1'b0;
        #1 check("R8", "fifo write with load pin high", 32'(fifo_wr_req), 32'd1);
        @(negedge wclk);
        wen_n = 1'b1;
        check("R5", "full offset after session break", 32'(full_ofs_w), 32'd1779);
        wr_reg(9'h00A);          // resumes at empty-high
        settle();
        check("R5", "empty offset after resumed session", 32'(empty_ofs_r), 32'd5205);
        check("R3", "full offset unchanged", 32'(full_ofs_w), 32'd1779);
        rd_reg("R5", 9'h00A);
        rd_reg("R6", 9'h0F3);
        rd_reg("R6", 9'h003);
        rd_reg("R3", 9'h055);
    endtask

    task automatic t_read_gating();
        @(negedge rclk);
        ld_n = 1'b0; ren_a_n = 1'b0; ren_b_n = 1'b1;
        #1 check("R8", "single read enable", 32'(fifo_rd_req), 32'd0);
        @(negedge rclk);
        check("R6", "no readback with one enable", 32'(cfg_dout), 32'h055);
        ld_n = 1'b1; ren_a_n = 1'b0; ren_b_n = 1'b0;
        #1 check("R8", "fifo read with load pin high", 32'(fifo_rd_req), 32'd1);
        @(negedge rclk);
        ren_a_n = 1'b1; ren_b_n = 1'b1;
        check("R6", "no readback with load pin high", 32'(cfg_dout), 32'h055);
        ld_n = 1'b0; ren_a_n = 1'b0; ren_b_n = 1'b0;
        #1 check("R8", "fifo read blocked in load session", 32'(fifo_rd_req), 32'd0);
        ren_a_n = 1'b1; ren_b_n = 1'b1;
        rd_reg("R6", 9'h00A);    // read selector did not move
    endtask

    task automatic t_two_enable();
        do_reset(1'b0);
        check("R2", "full offset reset", 32'(full_ofs_w), 32'd7);
        check("R2", "empty offset reset", 32'(empty_ofs_r), 32'd7);
        @(negedge wclk);
        ld_n = 1'b0; wen_n = 1'b0; din = 9'h1FF;
        #1 check("R8", "no fifo write with load pin low", 32'(fifo_wr_req), 32'd0);
        repeat (2) @(negedge wclk);
        wen_n = 1'b1;
        check("R1", "full offset ignored in two-enable mode", 32'(full_ofs_w), 32'd7);
        @(negedge rclk);
        ren_a_n = 1'b0; ren_b_n = 1'b0;
        #1 check("R8", "fifo read not blocked in two-enable mode", 32'(fifo_rd_req), 32'd1);
        repeat (2) @(negedge rclk);
        ren_a_n = 1'b1; ren_b_n = 1'b1;
        check("R1", "no readback in two-enable mode", 32'(cfg_dout), 32'd0);
        settle();
        check("R1", "empty offset ignored in two-enable mode", 32'(empty_ofs_r), 32'd7);
    endtask

    task automatic t_reload();
        do_reset(1'b1);
        wr_reg(9'h1FF);          // selector restarts at empty-low
        check("R2", "full offset unaffected", 32'(full_ofs_w), 32'd7);
        settle();
        check("R2", "write selector reset to empty-low", 32'(empty_ofs_r), 32'h1FF);
        rd_reg("R2", 9'h1FF);
        rd_reg("R2", 9'h000);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        t_reset_state();
        t_default_readback();
        t_full_sequence();
        t_sessions();
        t_read_gating();
        t_two_enable();
        t_reload();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge wclk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end
endmodule